// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Serializer

This block turns one stereo PCM sample pair per frame into a serial bit stream with its bit clock and frame clock. Each frame is 64 bit clocks long: a 32-bit slot for the left channel comes first, then a 32-bit slot for the right channel. Inside a slot the sample is placed at the start or at the end, and may be delayed by one bit clock from the frame clock edge. This gives standard I2S, left-justified and right-justified framing. The sample width is 16, 24 or 32 bits. Any slot bit not covered by the sample is driven as zero.

The bit clock and frame clock can come from two sources. As clock master, the block divides its system clock to make both. As slave, it follows external clocks. These pass through a synchronizer chain, and the block then detects their edges. A sample source such as a FIFO offers a left/right pair with a valid flag. The block takes the pair at the start of each frame. The block serializes only while both the global enable and the transmit enable are high.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While `rst` is high, `sdata_o`, `bclk_o` and `fclk_o` are low at the next clock edge, and `smp_ready` is low.
- R2: With `glb_en` high, `tx_en` low and master mode set, `bclk_o` rests at `cfg_bclk_inv`, `fclk_o` rests at the right-channel level (`~cfg_lr_swap`) and `sdata_o` is 0. `smp_ready` stays low, so no sample is taken.
- R3: In master mode, the internal bit clock starts low on activation and toggles every HALF_DIV system clocks. It first rises HALF_DIV cycles after activation. `bclk_o` is this clock XOR `cfg_bclk_inv`.
- R4: `sdata_o` and the master `fclk_o` change only on the data edge. With `cfg_bclk_inv`=0 this is the falling edge of the bit clock; with `cfg_bclk_inv`=1 it is the rising edge. The change is registered in the same system cycle as that bit clock edge.
- R5: A frame is 64 data edges. The first 32 carry the left slot and the last 32 the right slot. `fclk_o` equals `cfg_lr_swap` during the left slot and its inverse during the right slot, so with `cfg_lr_swap`=0 a low frame clock marks left.
- R6: `smp_ready` is high for exactly the cycle of the first data edge of a frame. If `smp_valid` is high in that cycle, `smp_left` and `smp_right` are taken for that frame. Otherwise the whole frame carries zeros.
- R7: `cfg_wlen` codes: 0 means 16 bits, 1 means 24 bits, 2 means 32 bits, and 3 is treated as 32 bits. The sample occupies the low bits of `smp_left`/`smp_right`; the bits above the word length are ignored.
- R8: With `cfg_rjust`=0, the word is sent MSB first from the first slot bit, and the rest of the slot is zero.
- R9: With `cfg_rjust`=1, the word ends on the last slot bit, and the leading slot bits are zero.
- R10: With `cfg_msb_delay`=1, the whole stream is delayed by one bit clock. The first bit of each slot then carries the last bit of the slot before it (zero after activation).
- R11: With `cfg_master`=0, `ext_bclk` and `ext_fclk` pass through SYNC_STAGES flops. A frame starts at a synchronized bit clock data edge where the frame clock has just moved to the left level. `bclk_o` and `fclk_o` are held low.
- R12: With `glb_en` low, the block stays idle whatever the level of `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global serial port enable |
| tx_en | input | 1 | Transmit path enable |
| cfg_master | input | 1 | 1: generate bit and frame clocks, 0: follow external clocks |
| cfg_bclk_inv | input | 1 | Bit clock polarity; picks which edge moves data |
| cfg_lr_swap | input | 1 | Frame clock level that marks the left slot |
| cfg_msb_delay | input | 1 | Delay the stream one bit clock after the frame edge |
| cfg_rjust | input | 1 | Place the word at the end of its slot |
| cfg_wlen | input | 2 | Word length code |
| smp_valid | input | 1 | Sample pair available |
| smp_left | input | SLOT_W | Left sample, right-aligned |
| smp_right | input | SLOT_W | Right sample, right-aligned |
| smp_ready | output | 1 | Sample pair taken this cycle (when valid) |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_fclk | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |

## Verification
Every output in master mode is a register. It updates at the clock edge that ends the cycle carrying the internal data-edge strobe, so a new bit, a frame clock change and the matching bit clock edge all appear together one cycle after that strobe. The first rising bit clock comes HALF_DIV cycles after the enables go high. In slave mode, an external edge moves `sdata_o` SYNC_STAGES+1 clock edges later. The bench model advances the same counts at each rising edge and compares every output at the falling edge. Stimulus changes 2 ns after a rising edge, so neither side ever samples a value in transition.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  typedef enum logic [1:0] {
    WLEN_16   = 2'd0,
    WLEN_24   = 2'd1,
    WLEN_32   = 2'd2,
    WLEN_RSVD = 2'd3
  } wlen_code_e;

  // Significant bits for a word length code, capped at the slot width.
  function automatic int unsigned word_bits(input logic [1:0] code, input int unsigned slot_w);
    int unsigned n;
    case (wlen_code_e'(code))
      WLEN_16: n = 16;
      WLEN_24: n = 24;
      default: n = 32;
    endcase
    if (n > slot_w) n = slot_w;
    return n;
  endfunction

endpackage

// File: rtl/i2stx_clkgen.sv
module i2stx_clkgen #(
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic master_i,
  input  logic bclk_inv_i,
  input  logic lr_swap_i,
  input  logic ext_bclk_i,
  input  logic ext_fclk_i,
  output logic chg_o,
  output logic frame_edge_o,
  output logic bclk_lvl_o
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;

  logic [DIV_W-1:0]       div_q;
  logic                   phase_q;
  logic                   tick;
  logic [SYNC_STAGES-1:0] bsync_q, fsync_q;
  logic                   pb, pb_q, fall, lr_now, lr_prev_q;

  // Master divider: phase toggles every HALF_DIV cycles while active.
  assign tick = (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  // Slave front end: synchronizer chains, then edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      bsync_q   <= '0;
      fsync_q   <= '0;
      pb_q      <= 1'b0;
      lr_prev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[SYNC_STAGES-2:0], ext_bclk_i};
      fsync_q <= {fsync_q[SYNC_STAGES-2:0], ext_fclk_i};
      pb_q    <= pb;
      if (fall) lr_prev_q <= lr_now;
    end
  end

  assign pb     = bsync_q[SYNC_STAGES-1] ^ bclk_inv_i;
  assign fall   = pb_q & ~pb;
  assign lr_now = (fsync_q[SYNC_STAGES-1] == lr_swap_i);

  assign frame_edge_o = fall & lr_now & ~lr_prev_q;
  assign chg_o        = active_i & (master_i ? (tick & phase_q) : fall);
  assign bclk_lvl_o   = active_i & (tick ? ~phase_q : phase_q);

endmodule

// File: rtl/i2stx_frame.sv
module i2stx_frame
  import i2stx_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic [SLOT_W-1:0]   left_i,
  input  logic [SLOT_W-1:0]   right_i,
  input  logic [1:0]          wlen_i,
  input  logic                rjust_i,
  output logic [2*SLOT_W-1:0] image_o
);
  localparam int SH_W = $clog2(SLOT_W + 1);

  logic [SH_W-1:0]   nbits;
  logic [SH_W-1:0]   pad;
  logic [SLOT_W-1:0] mask;

  assign nbits = SH_W'(word_bits(wlen_i, SLOT_W));
  assign pad   = SH_W'(SLOT_W) - nbits;
  assign mask  = {SLOT_W{1'b1}} >> pad;

  // Channel 0 (left) lands in the upper slot and is sent first.
  for (genvar ch = 0; ch < 2; ch++) begin : g_slot
    logic [SLOT_W-1:0] word, kept;
    assign word = (ch == 0) ? left_i : right_i;
    assign kept = word & mask;
    assign image_o[(2-ch)*SLOT_W-1 -: SLOT_W] = rjust_i ? kept : (kept << pad);
  end

endmodule

// File: rtl/i2stx_shift.sv
module i2stx_shift #(
  parameter int SLOT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active_i,
  input  logic                master_i,
  input  logic                delay_i,
  input  logic                lr_swap_i,
  input  logic                chg_i,
  input  logic                slave_edge_i,
  input  logic                valid_i,
  input  logic [2*SLOT_W-1:0] image_i,
  output logic                load_o,
  output logic                sdata_o,
  output logic                fclk_o
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int CNT_W = $clog2(FRAME);

  logic [FRAME-1:0] sr_q, fresh;
  logic [CNT_W-1:0] pos_q, pos_next;
  logic             first_q, last_q;
  logic             start, advance, nb;

  assign start    = master_i ? (first_q || pos_q == CNT_W'(FRAME - 1)) : slave_edge_i;
  assign advance  = chg_i && (start || !first_q);
  assign load_o   = chg_i && start;
  assign fresh    = valid_i ? image_i : '0;
  assign nb       = start ? fresh[FRAME-1] : sr_q[FRAME-2];
  assign pos_next = start ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      sr_q    <= '0;
      pos_q   <= '0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
      sdata_o <= 1'b0;
    end else if (advance) begin
      sr_q    <= start ? fresh : (sr_q << 1);
      pos_q   <= pos_next;
      first_q <= 1'b0;
      last_q  <= nb;
      sdata_o <= delay_i ? last_q : nb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !master_i)
      fclk_o <= 1'b0;
    else if (!active_i)
      fclk_o <= ~lr_swap_i;
    else if (advance)
      fclk_o <= (pos_next < CNT_W'(SLOT_W)) ? lr_swap_i : ~lr_swap_i;
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (sdata_o == 1'b0));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active_i && !chg_i) |=> $stable(sdata_o));

  assert_take_left_R6: assert property (@(posedge clk) disable iff (rst)
    (load_o && master_i) |=> (fclk_o == lr_swap_i));

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int SLOT_W      = 32,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              tx_en,
  input  logic              cfg_master,
  input  logic              cfg_bclk_inv,
  input  logic              cfg_lr_swap,
  input  logic              cfg_msb_delay,
  input  logic              cfg_rjust,
  input  logic [1:0]        cfg_wlen,
  input  logic              smp_valid,
  input  logic [SLOT_W-1:0] smp_left,
  input  logic [SLOT_W-1:0] smp_right,
  output logic              smp_ready,
  input  logic              ext_bclk,
  input  logic              ext_fclk,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              sdata_o
);
  logic                active, chg, frame_edge, bclk_lvl;
  logic [2*SLOT_W-1:0] image;

  assign active = glb_en & tx_en;

  i2stx_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst(rst), .active_i(active), .master_i(cfg_master),
    .bclk_inv_i(cfg_bclk_inv), .lr_swap_i(cfg_lr_swap),
    .ext_bclk_i(ext_bclk), .ext_fclk_i(ext_fclk),
    .chg_o(chg), .frame_edge_o(frame_edge), .bclk_lvl_o(bclk_lvl)
  );

  i2stx_frame #(.SLOT_W(SLOT_W)) u_frame (
    .left_i(smp_left), .right_i(smp_right), .wlen_i(cfg_wlen),
    .rjust_i(cfg_rjust), .image_o(image)
  );

  i2stx_shift #(.SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst(rst), .active_i(active), .master_i(cfg_master),
    .delay_i(cfg_msb_delay), .lr_swap_i(cfg_lr_swap), .chg_i(chg),
    .slave_edge_i(frame_edge), .valid_i(smp_valid), .image_i(image),
    .load_o(smp_ready), .sdata_o(sdata_o), .fclk_o(fclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !cfg_master) bclk_o <= 1'b0;
    else                    bclk_o <= bclk_lvl ^ cfg_bclk_inv;
  end

  assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |=> (bclk_o == 1'b0 && fclk_o == 1'b0));

  assert_bclk_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && active && chg) |=> (bclk_o == cfg_bclk_inv));

endmodule

// File: tb/test_i2s_tx_serializer.sv
module test_i2s_tx_serializer;
  localparam int H = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic glb_en = 0, tx_en = 0, cfg_master = 1, cfg_bclk_inv = 0, cfg_lr_swap = 0;
  logic cfg_msb_delay = 0, cfg_rjust = 0;
  logic [1:0] cfg_wlen = 2'd2;
  logic smp_valid = 0;
  logic [31:0] smp_left = 32'h8000_0001, smp_right = 32'h7FFF_FFFE;
  logic smp_ready, ext_bclk = 0, ext_fclk = 1, bclk_o, fclk_o, sdata_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;
  bit slv_run = 0;
  logic [31:0] seed = 32'h1234_5678;

  i2s_tx_serializer #(.SLOT_W(32), .HALF_DIV(H), .SYNC_STAGES(2)) i_i2s_tx_serializer (
    .clk(clk), .rst(rst), .glb_en(glb_en), .tx_en(tx_en), .cfg_master(cfg_master),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_lr_swap(cfg_lr_swap), .cfg_msb_delay(cfg_msb_delay),
    .cfg_rjust(cfg_rjust), .cfg_wlen(cfg_wlen), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .smp_ready(smp_ready),
    .ext_bclk(ext_bclk), .ext_fclk(ext_fclk), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .sdata_o(sdata_o)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_div = 0, m_n = 0;
  bit m_p = 0, m_first = 1, m_last = 0, m_sd = 0, m_fclk = 0, m_bclk = 0;
  bit m_bs1 = 0, m_bs2 = 0, m_fs1 = 0, m_fs2 = 0, m_pbd = 0, m_lrprev = 0;
  logic [31:0] m_L = 0, m_R = 0;

  function automatic bit bit_at(int n, logic [31:0] l, logic [31:0] r, logic [1:0] wl, bit rj);
    int w, k, off, j;
    logic [31:0] word;
    w    = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
    word = (n < 32) ? l : r;
    k    = n % 32;
    off  = rj ? 32 - w : 0;
    j    = k - off;
    if (j < 0 || j >= w) return 1'b0;
    return word[w-1-j];
  endfunction

  always @(posedge clk) begin
    bit act, pb, fall, lrnow, sedge, chg, tick, start, nb;
    if (rst) begin
      m_div = 0; m_n = 0; m_p = 0; m_first = 1; m_last = 0; m_sd = 0; m_fclk = 0; m_bclk = 0;
      m_bs1 = 0; m_bs2 = 0; m_fs1 = 0; m_fs2 = 0; m_pbd = 0; m_lrprev = 0;
    end else begin
      act   = glb_en && tx_en;
      pb    = m_bs2 ^ cfg_bclk_inv;
      fall  = m_pbd && !pb;
      lrnow = (m_fs2 == cfg_lr_swap);
      sedge = fall && lrnow && !m_lrprev;
      if (fall) m_lrprev = lrnow;
      m_pbd = pb; m_bs2 = m_bs1; m_bs1 = ext_bclk; m_fs2 = m_fs1; m_fs1 = ext_fclk;
      chg = 0;
      if (!act) begin
        m_div = 0; m_p = 0;
      end else begin
        tick = (m_div == H - 1);
        if (cfg_master) chg = tick && m_p;
        if (tick) begin m_div = 0; m_p = !m_p; end
        else m_div++;
      end
      if (!cfg_master) chg = act && fall;
      m_bclk = cfg_master ? (m_p ^ cfg_bclk_inv) : 1'b0;
      if (!act) begin
        m_first = 1; m_n = 0; m_last = 0; m_sd = 0;
      end else if (chg) begin
        start = cfg_master ? (m_first || m_n == 63) : sedge;
        if (start || !m_first) begin
          if (start) begin
            m_n = 0; m_first = 0;
            m_L = smp_valid ? smp_left : 32'd0;
            m_R = smp_valid ? smp_right : 32'd0;
          end else m_n = (m_n + 1) % 64;
          nb = bit_at(m_n, m_L, m_R, cfg_wlen, cfg_rjust);
          m_sd = cfg_msb_delay ? m_last : nb;
          m_last = nb;
          if (cfg_master) m_fclk = (m_n < 32) ? cfg_lr_swap : !cfg_lr_swap;
        end
      end
      if (!cfg_master) m_fclk = 0;
      else if (!act) m_fclk = !cfg_lr_swap;
    end
  end

  task automatic check(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, what, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit act, chg_now, start_now, rdy;
    if (!done) begin
      act = glb_en && tx_en && !rst;
      if (cfg_master) begin
        chg_now   = act && (m_div == H - 1) && m_p;
        start_now = m_first || m_n == 63;
      end else begin
        chg_now   = act && m_pbd && !(m_bs2 ^ cfg_bclk_inv);
        start_now = (m_fs2 == cfg_lr_swap) && !m_lrprev;
      end
      rdy = chg_now && start_now;
      check("sdata_o",   sdata_o,   m_sd);
      check("bclk_o",    bclk_o,    m_bclk);
      check("fclk_o",    fclk_o,    m_fclk);
      check("smp_ready", smp_ready, rdy);
    end
  end

  // sample source: new pair after each accepted take
  always @(posedge clk) begin
    if (!rst && smp_ready && smp_valid) begin
      #2;
      seed = seed * 32'd1664525 + 32'd1013904223;
      smp_left  <= seed;
      smp_right <= {seed[15:0], seed[31:16]} ^ 32'hA5A5_5A5A;
    end
  end

  // external clock source for slave mode
  initial begin
    int ediv, epos;
    ediv = 0; epos = 63;
    forever begin
      @(posedge clk); #2;
      if (!slv_run) begin
        ediv = 0; epos = 63; ext_bclk = 0; ext_fclk = !cfg_lr_swap;
      end else begin
        ediv++;
        if (ediv == 4) begin
          ediv = 0;
          if (ext_bclk) begin
            ext_bclk = 0;
            epos = (epos + 1) % 64;
            ext_fclk = (epos < 32) ? cfg_lr_swap : !cfg_lr_swap;
          end else ext_bclk = 1;
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setup(bit m, bit inv, bit sw, bit dly, bit rj, logic [1:0] wl);
    tx_en = 0;
    wait_cyc(4);
    cfg_master = m; cfg_bclk_inv = inv; cfg_lr_swap = sw;
    cfg_msb_delay = dly; cfg_rjust = rj; cfg_wlen = wl;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(4);
    // R1: reset state (outputs registered low during reset)
    cur_req = "R1";
    check("reset sdata_o", sdata_o, 1'b0);
    check("reset bclk_o", bclk_o, 1'b0);
    check("reset fclk_o", fclk_o, 1'b0);
    check("reset smp_ready", smp_ready, 1'b0);
    rst = 0;
    smp_valid = 1;
    // R2: global enable alone keeps idle levels
    cur_req = "R2";
    glb_en = 1; tx_en = 0; cfg_bclk_inv = 1;
    wait_cyc(20);
    // R12: tx enable without global enable does nothing
    cur_req = "R12";
    glb_en = 0; tx_en = 1;
    wait_cyc(30);
    glb_en = 1;
    // I2S framing, 32-bit words
    setup(1, 0, 0, 1, 0, 2'd2);
    cur_req = "R3,R4,R5,R6,R10";
    tx_en = 1;
    wait_cyc(600);
    // left-justified 16-bit, inverted clocks, swapped LR
    setup(1, 1, 1, 0, 0, 2'd0);
    cur_req = "R7,R8,R3,R5";
    tx_en = 1;
    wait_cyc(600);
    // right-justified 24-bit
    setup(1, 0, 0, 0, 1, 2'd1);
    cur_req = "R7,R9";
    tx_en = 1;
    wait_cyc(600);
    // underrun: no valid sample for a while
    cur_req = "R6";
    smp_valid = 0;
    wait_cyc(300);
    smp_valid = 1;
    wait_cyc(300);
    // reserved word length code, I2S delay
    setup(1, 0, 0, 1, 0, 2'd3);
    cur_req = "R7";
    tx_en = 1;
    wait_cyc(600);
    // slave mode following external clocks
    setup(0, 0, 0, 1, 0, 2'd2);
    cur_req = "R11";
    tx_en = 1;
    wait_cyc(5);
    slv_run = 1;
    wait_cyc(1200);
    slv_run = 0;
    tx_en = 0;
    wait_cyc(10);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s: actual hung expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule